// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable pins for a parallel RGB panel, plus a frame-done status flag and a double-buffered framebuffer base address. Every timing figure comes from configuration inputs. These figures are the line length in clocks, the frame length in lines, the two sync widths, the two wait counts and the active pixel and line counts. Each pin has its own polarity select. A line begins with its sync pulse. The active window opens once the wait count has elapsed from that start. The wait count is therefore the sync width plus the back porch.

The surrounding logic can write a new framebuffer address at any moment. The address the fetch engine reads changes only at the last clock of a frame, so a frame never starts from a half-updated base. The frame-done flag rises when the last active line has ended. It stays set until a clear strobe arrives. Pixel fetch and pixel-clock generation sit outside this block. The configuration is a set of plain level inputs and carries no handshake.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `run` is high, the position after the n-th clock edge since `run` rose is h = n mod h_total and v = (n / h_total) mod v_total. The horizontal sync is active exactly when h < h_sync_w.
- R2: The vertical sync is active for whole lines, exactly when v < v_sync_w.
- R3: Data enable is active exactly when h_wait <= h < h_wait + h_active and v_wait <= v < v_wait + v_active.
- R4: Each pin has a polarity select (1 = active high). When the select is 1 the pin is 1 while active and 0 while inactive. When the select is 0 the pin levels are the other way round.
- R5: While `sync_en` is 0, both sync pins sit at their inactive level, and data enable keeps its normal timing.
- R6: While `run` is 0, all three pins sit at their inactive level from the next edge on, and the position is held at h = 0, v = 0. Raising `run` again restarts at position 0.
- R7: A pulse on `nxt_wr` stores `nxt_addr` as the next address at that edge. `cur_addr` takes the previously stored next address at the edge where h = h_total-1 and v = v_total-1, and it changes at no other edge while running. While `run` is 0, `cur_addr` takes the stored next address at every edge.
- R8: `done_irq` is set by the edge at h = h_total-1, v = v_wait + v_active - 1. It stays set until an edge with `done_clr` high. When set and clear fall on the same edge, the set wins.
- R9: After reset all pins are at their inactive level, `done_irq` is 0 and `cur_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counters advance while high |
| sync_en | input | 1 | Allows sync pulses onto the pins |
| hs_act_hi | input | 1 | Horizontal sync polarity, 1 = active high |
| vs_act_hi | input | 1 | Vertical sync polarity, 1 = active high |
| de_act_hi | input | 1 | Data-enable polarity, 1 = active high |
| h_total | input | 12 | Clocks per line |
| h_sync_w | input | 12 | Horizontal sync width in clocks |
| h_wait | input | 12 | Clocks from line start to first active pixel |
| h_active | input | 12 | Active pixels per line |
| v_total | input | 12 | Lines per frame |
| v_sync_w | input | 12 | Vertical sync width in lines |
| v_wait | input | 12 | Lines from frame start to first active line |
| v_active | input | 12 | Active lines per frame |
| nxt_wr | input | 1 | Write strobe for the next address |
| nxt_addr | input | 32 | Next framebuffer address |
| cur_addr | output | 32 | Framebuffer address in use for this frame |
| done_clr | input | 1 | Clears the frame-done flag |
| done_irq | output | 1 | Frame-done flag |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |

## Verification
The assertions assume that the timing inputs stay constant while `run` is high. They also assume h_wait + h_active <= h_total and v_wait + v_active <= v_total, with nonzero totals. The stimulus changes timing and polarity only while `run` is low, and it uses only configurations that fit in their totals. Address writes and clear strobes arrive at any cycle, including the frame-end and flag-set edges, and these are exactly the cases the properties judge.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;
  parameter int unsigned CW = 12;

  typedef struct packed {
    logic [CW-1:0] total;
    logic [CW-1:0] sync_w;
    logic [CW-1:0] wait_c;
    logic [CW-1:0] active;
  } axis_cfg_t;
endpackage

// File: rtl/lcd_tim_axis.sv
module lcd_tim_axis
  import lcd_tim_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      step,
  input  axis_cfg_t cfg,
  output logic      last,
  output logic      sync_act,
  output logic      win_act,
  output logic      win_last
);
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_nx;
  logic [CW:0]   win_end;

  always_comb begin
    cnt_nx   = {1'b0, cnt} + 1'b1;
    win_end  = {1'b0, cfg.wait_c} + {1'b0, cfg.active};
    last     = cnt_nx >= {1'b0, cfg.total};
    sync_act = cnt < cfg.sync_w;
    win_act  = (cnt >= cfg.wait_c) && ({1'b0, cnt} < win_end);
    win_last = (cfg.active != '0) && (cnt_nx == win_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (step)   cnt <= last ? '0 : cnt_nx[CW-1:0];
  end
endmodule

// File: rtl/lcd_fb_addr.sv
module lcd_fb_addr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          frame_end,
  input  logic          wr,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt <= '0;
      cur <= '0;
    end else begin
      if (wr)                 nxt <= wdata;
      if (!run || frame_end)  cur <= nxt;
    end
  end
endmodule

// File: rtl/lcd_done_flag.sv
module lcd_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_tim_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          sync_en,
  input  logic          hs_act_hi,
  input  logic          vs_act_hi,
  input  logic          de_act_hi,
  input  logic [CW-1:0] h_total,
  input  logic [CW-1:0] h_sync_w,
  input  logic [CW-1:0] h_wait,
  input  logic [CW-1:0] h_active,
  input  logic [CW-1:0] v_total,
  input  logic [CW-1:0] v_sync_w,
  input  logic [CW-1:0] v_wait,
  input  logic [CW-1:0] v_active,
  input  logic          nxt_wr,
  input  logic [AW-1:0] nxt_addr,
  output logic [AW-1:0] cur_addr,
  input  logic          done_clr,
  output logic          done_irq,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o
);
  localparam int unsigned NAX = 2;

  axis_cfg_t        cfg [NAX];
  logic [NAX-1:0]   step, last, sync_act, win_act, win_last;
  logic             frame_end, done_set;
  logic             hs_q, vs_q, de_q;

  assign cfg[0] = '{total: h_total, sync_w: h_sync_w, wait_c: h_wait, active: h_active};
  assign cfg[1] = '{total: v_total, sync_w: v_sync_w, wait_c: v_wait, active: v_active};
  assign step   = {last[0], 1'b1};

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    lcd_tim_axis u_axis (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .step     (step[a]),
      .cfg      (cfg[a]),
      .last     (last[a]),
      .sync_act (sync_act[a]),
      .win_act  (win_act[a]),
      .win_last (win_last[a])
    );
  end

  assign frame_end = run & last[0] & last[1];
  assign done_set  = run & last[0] & win_last[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
    end else begin
      hs_q <= run & sync_en & sync_act[0];
      vs_q <= run & sync_en & sync_act[1];
      de_q <= run & win_act[0] & win_act[1];
    end
  end

  assign hsync_o = hs_act_hi ? hs_q : ~hs_q;
  assign vsync_o = vs_act_hi ? vs_q : ~vs_q;
  assign de_o    = de_act_hi ? de_q : ~de_q;

  lcd_fb_addr #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .frame_end (frame_end),
    .wr        (nxt_wr),
    .wdata     (nxt_addr),
    .cur       (cur_addr)
  );

  lcd_done_flag u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (done_set),
    .clr   (done_clr),
    .flag  (done_irq)
  );
endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          sync_en,
  input logic          hs_act_hi,
  input logic          vs_act_hi,
  input logic          de_act_hi,
  input logic          done_clr,
  input logic          done_irq,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          de_o,
  input logic [AW-1:0] cur_addr,
  input logic          frame_end,
  input logic          h_win_last,
  input logic          v_win_act
);
  // R5
  sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (hsync_o != hs_act_hi) && (vsync_o != vs_act_hi));

  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (de_o != de_act_hi) && (hsync_o != hs_act_hi));

  // R3
  de_last_px_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_win_last && v_win_act) |=> (de_o == de_act_hi));

  // R7
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_addr) |-> $past(frame_end || !run));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !done_clr) |=> done_irq);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(run));
endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .sync_en    (sync_en),
  .hs_act_hi  (hs_act_hi),
  .vs_act_hi  (vs_act_hi),
  .de_act_hi  (de_act_hi),
  .done_clr   (done_clr),
  .done_irq   (done_irq),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .de_o       (de_o),
  .cur_addr   (cur_addr),
  .frame_end  (frame_end),
  .h_win_last (win_last[0]),
  .v_win_act  (win_act[1])
);

// File: tb/tb_lcd_sync_gen.sv
module tb_lcd_sync_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, sync_en = 1'b1;
  logic        hs_act_hi = 1'b1, vs_act_hi = 1'b1, de_act_hi = 1'b1;
  logic [11:0] h_total, h_sync_w, h_wait, h_active;
  logic [11:0] v_total, v_sync_w, v_wait, v_active;
  logic        nxt_wr = 1'b0, done_clr = 1'b0;
  logic [31:0] nxt_addr = '0;
  logic [31:0] cur_addr;
  logic        done_irq, hsync_o, vsync_o, de_o;

  int checks = 0, fails = 0;
  logic [31:0] exp_cur = '0, exp_nxt = '0;
  logic        exp_irq = 1'b0;

  always #5 clk = ~clk;

  lcd_sync_gen dut (
    .clk(clk), .rst_n(rst_n), .run(run), .sync_en(sync_en),
    .hs_act_hi(hs_act_hi), .vs_act_hi(vs_act_hi), .de_act_hi(de_act_hi),
    .h_total(h_total), .h_sync_w(h_sync_w), .h_wait(h_wait), .h_active(h_active),
    .v_total(v_total), .v_sync_w(v_sync_w), .v_wait(v_wait), .v_active(v_active),
    .nxt_wr(nxt_wr), .nxt_addr(nxt_addr), .cur_addr(cur_addr),
    .done_clr(done_clr), .done_irq(done_irq),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic pin(input logic pol, input logic a);
    return pol ? a : ~a;
  endfunction

  task automatic set_cfg(input int ht, hs, hw, ha, vt, vs, vw, va);
    h_total = 12'(ht); h_sync_w = 12'(hs); h_wait = 12'(hw); h_active = 12'(ha);
    v_total = 12'(vt); v_sync_w = 12'(vs); v_wait = 12'(vw); v_active = 12'(va);
  endtask

  task automatic stop_and_check();
    run = 1'b0;
    tick();
    exp_cur = exp_nxt;
    chk(hsync_o == ~hs_act_hi, "R6 hsync idle", hsync_o, ~hs_act_hi);
    chk(vsync_o == ~vs_act_hi, "R6 vsync idle", vsync_o, ~vs_act_hi);
    chk(de_o == ~de_act_hi, "R6 de idle", de_o, ~de_act_hi);
    chk(cur_addr == exp_cur, "R7 follow while stopped", cur_addr, exp_cur);
    done_clr = 1'b1;
    tick();
    done_clr = 1'b0;
    exp_irq = 1'b0;
    chk(done_irq == 1'b0, "R8 clear while stopped", done_irq, 0);
  endtask

  task automatic sweep(input int frames, input logic [31:0] abase);
    int ht, vt, fr, dn;
    ht = int'(h_total); vt = int'(v_total);
    fr = ht * vt;
    dn = (int'(v_wait) + int'(v_active) - 1) * ht + ht - 1;
    run = 1'b1;
    for (int n = 0; n < frames * fr; n++) begin
      int h, v;
      logic wr, clr, fe, set, ha, va, da;
      logic [31:0] wd;
      clr = (n == dn + 5) || (n == fr + dn);
      wr  = (n == 7) || (n == fr - 1);
      wd  = (n == 7) ? abase : abase + 32'h100;
      done_clr = clr; nxt_wr = wr; nxt_addr = wd;
      tick();
      h = n % ht;
      v = (n / ht) % vt;
      fe  = (h == ht - 1) && (v == vt - 1);
      set = (h == ht - 1) && (v == int'(v_wait) + int'(v_active) - 1);
      if (fe) exp_cur = exp_nxt;
      if (wr) exp_nxt = wd;
      exp_irq = set | (exp_irq & ~clr);
      ha = sync_en && (h < int'(h_sync_w));
      va = sync_en && (v < int'(v_sync_w));
      da = (h >= int'(h_wait)) && (h < int'(h_wait) + int'(h_active)) &&
           (v >= int'(v_wait)) && (v < int'(v_wait) + int'(v_active));
      chk(hsync_o == pin(hs_act_hi, ha), sync_en ? "R1 R4 hsync" : "R5 hsync off",
          hsync_o, pin(hs_act_hi, ha));
      chk(vsync_o == pin(vs_act_hi, va), sync_en ? "R2 R4 vsync" : "R5 vsync off",
          vsync_o, pin(vs_act_hi, va));
      chk(de_o == pin(de_act_hi, da), "R3 R4 de", de_o, pin(de_act_hi, da));
      chk(done_irq == exp_irq, "R8 done flag", done_irq, exp_irq);
      chk(cur_addr == exp_cur, "R7 current address", cur_addr, exp_cur);
    end
    done_clr = 1'b0; nxt_wr = 1'b0;
    stop_and_check();
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    set_cfg(10, 2, 4, 5, 6, 1, 2, 3);
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    // R9 reset state
    chk(hsync_o == 1'b0, "R9 hsync reset", hsync_o, 0);
    chk(vsync_o == 1'b0, "R9 vsync reset", vsync_o, 0);
    chk(de_o == 1'b0, "R9 de reset", de_o, 0);
    chk(done_irq == 1'b0, "R9 done reset", done_irq, 0);
    chk(cur_addr == 32'h0, "R9 address reset", cur_addr, 0);

    nxt_wr = 1'b1; nxt_addr = 32'h0000_1000;
    tick();
    nxt_wr = 1'b0; exp_nxt = 32'h0000_1000;
    tick();
    exp_cur = exp_nxt;
    chk(cur_addr == exp_cur, "R7 initial load while stopped", cur_addr, exp_cur);

    sweep(3, 32'h0002_0000);

    hs_act_hi = 1'b0; vs_act_hi = 1'b0; de_act_hi = 1'b0;
    set_cfg(7, 1, 2, 4, 5, 2, 3, 2);
    tick();
    sweep(2, 32'h0003_0000);

    sync_en = 1'b0; hs_act_hi = 1'b1; de_act_hi = 1'b1;
    set_cfg(8, 3, 3, 5, 4, 1, 1, 3);
    tick();
    sweep(2, 32'h0004_0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule